// File: doc/BRIEF.md
# Multiprocessor-Aware Serial Frame Receiver

This block recovers asynchronous serial frames from a single input line and places the received bytes in a two-entry receive queue. A frame is a low start bit, eight data bits sent least significant bit first, an optional ninth-bit slot, and a high stop bit. The ninth-bit slot serves one of two purposes. It can carry a general-purpose extra bit, or it can carry a parity bit that is checked against one of four parity rules.

Each queue entry stores one status bit alongside its byte, and the entry at the head of the queue is shown on the read port. This status bit is the received ninth bit when the extra-bit mode is on and parity is off. In every other mode it is the received stop-bit value.

For bus topologies with one master and several listeners, a multiprocessor mode gates the receive interrupt. In this mode only address frames raise it. An address frame is one whose status bit is 1. Data frames are still stored, but they raise no interrupt. Address comparison is left to the software that services the interrupt.

Top module: `uart_mp_rx`

## Requirements
- R1: After reset `rd_valid`, `perr`, `ovr` and `rx_irq` are all 0.
- R2: The line is sampled once per `os_tick`, 16 ticks per bit. A low level seen in idle is confirmed on the 8th tick. If the line is high again by then, the event is discarded as a glitch and no frame is produced. Data bits are sampled at mid-bit, least significant bit first.
- R3: A ninth-bit slot is present between the data bits and the stop bit whenever `ninth_en` or `par_en` is 1. Otherwise the stop bit follows bit 7 directly.
- R4: The stored status bit (`rd_bit9` for the head entry) is the ninth bit when `ninth_en`=1 and `par_en`=0. Otherwise it is the stop-bit value, so `par_en`=1 overrides `ninth_en`.
- R5: With `par_en`=1, the ninth bit is compared against the parity rule selected by `par_sel`. The encodings are 2'b00 odd (total of ones, parity included, is odd), 2'b01 even, 2'b10 mark (bit must be 1) and 2'b11 space (bit must be 0). A mismatch sets `perr`.
- R6: `perr` stays 1 until a `clr_perr` pulse, even when later frames have correct parity. A new error in the same cycle as the clear wins.
- R7: With `mp_en`=1, a stored frame raises `rx_irq` only if its status bit is 1. Frames with a status bit of 0 are stored silently.
- R8: With `mp_en`=0, every stored frame raises `rx_irq` as a single-cycle pulse.
- R9: The queue holds 2 entries in arrival order. `pop` removes the head. A `pop` while the queue is empty has no effect.
- R10: A frame that completes while the queue holds 2 entries is dropped. It raises no interrupt and sets `ovr`, which stays 1 until a `clr_ovr` pulse. The stored entries are unchanged.
- R11: A `pop` in the same cycle that a frame is stored into an empty queue leaves the new frame in the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling strobe, 16 per bit time |
| rx_in | input | 1 | Serial input line, idle high |
| ninth_en | input | 1 | Enables the ninth-bit slot as an extra bit |
| par_en | input | 1 | Enables the ninth-bit slot as a parity bit |
| par_sel | input | 2 | Parity rule: 00 odd, 01 even, 10 mark, 11 space |
| mp_en | input | 1 | Multiprocessor mode: interrupt on address frames only |
| pop | input | 1 | Removes the head entry of the queue |
| clr_perr | input | 1 | Clears the parity error flag |
| clr_ovr | input | 1 | Clears the overrun flag |
| rd_data | output | 8 | Data byte of the head entry |
| rd_bit9 | output | 1 | Status bit of the head entry |
| rd_valid | output | 1 | Queue holds at least one entry |
| perr | output | 1 | Sticky parity error flag |
| ovr | output | 1 | Sticky overrun flag |
| rx_irq | output | 1 | Receive interrupt pulse |

## Verification
A frame can be stored in the same cycle that software pops the queue. The bench provokes this by holding `pop` high while a frame arrives into an empty queue. It releases `pop` on the first falling edge at which `rd_valid` is seen. The new byte must then still be readable with the right data and status bit. A second overlap is a frame that completes against a full queue. Here the dropped frame must set `ovr` without an interrupt pulse, and the two earlier entries must read back in order.

// File: rtl/uart_mp_rx_pkg.sv
package uart_mp_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_NINTH = 3'd3,
        ST_STOP  = 3'd4
    } rx_state_e;

    localparam logic [1:0] PAR_ODD   = 2'b00;
    localparam logic [1:0] PAR_EVEN  = 2'b01;
    localparam logic [1:0] PAR_MARK  = 2'b10;
    localparam logic [1:0] PAR_SPACE = 2'b11;

    typedef struct packed {
        logic perr;
        logic ovr;
        logic irq;
    } flag_s;

endpackage

// File: rtl/uart_mp_rx_sync.sv
module uart_mp_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/uart_mp_rx_frame.sv
module uart_mp_rx_frame
    import uart_mp_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              line,
    input  logic              slot9_en,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              bit9,
    output logic              stop_bit
);
    localparam int CNT_W = $clog2(OSR);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OSR - 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    typedef struct packed {
        rx_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] shreg;
        logic              b9;
        logic              stopb;
        logic              done;
    } frm_s;

    frm_s st_d, st_q;
    logic sample_now;

    always_comb begin
        st_d       = st_q;
        st_d.done  = 1'b0;
        sample_now = tick && (st_q.cnt == LAST_CNT);
        case (st_q.state)
            ST_IDLE: begin
                if (tick && !line) begin
                    st_d.state = ST_START;
                    st_d.cnt   = CNT_W'(1);
                end
            end
            ST_START: begin
                if (tick) begin
                    if (st_q.cnt == MID_CNT) begin
                        st_d.cnt = '0;
                        st_d.idx = '0;
                        st_d.state = line ? ST_IDLE : ST_DATA;
                    end else begin
                        st_d.cnt = st_q.cnt + CNT_W'(1);
                    end
                end
            end
            ST_DATA: begin
                if (tick) st_d.cnt = st_q.cnt + CNT_W'(1);
                if (sample_now) begin
                    st_d.shreg = {line, st_q.shreg[DATA_W-1:1]};
                    if (st_q.idx == LAST_IDX)
                        st_d.state = slot9_en ? ST_NINTH : ST_STOP;
                    else
                        st_d.idx = st_q.idx + IDX_W'(1);
                end
            end
            ST_NINTH: begin
                if (tick) st_d.cnt = st_q.cnt + CNT_W'(1);
                if (sample_now) begin
                    st_d.b9    = line;
                    st_d.state = ST_STOP;
                end
            end
            ST_STOP: begin
                if (tick) st_d.cnt = st_q.cnt + CNT_W'(1);
                if (sample_now) begin
                    st_d.stopb = line;
                    st_d.done  = 1'b1;
                    st_d.state = ST_IDLE;
                end
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.state <= ST_IDLE;
            st_q.cnt   <= '0;
            st_q.idx   <= '0;
            st_q.shreg <= '0;
            st_q.b9    <= 1'b0;
            st_q.stopb <= 1'b1;
            st_q.done  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done     = st_q.done;
    assign data     = st_q.shreg;
    assign bit9     = st_q.b9;
    assign stop_bit = st_q.stopb;
endmodule

// File: rtl/uart_mp_rx_fifo.sv
module uart_mp_rx_fifo #(
    parameter int W     = 9,
    parameter int DEPTH = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               wdata,
    input  logic                       pop,
    output logic [W-1:0]               head,
    output logic                       not_empty,
    output logic                       accept,
    output logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wp;
        logic [PTR_W-1:0]        rp;
        logic [LVL_W-1:0]        lvl;
    } fifo_s;

    fifo_s fq_d, fq_q;
    logic  do_push, do_pop;

    always_comb begin
        fq_d    = fq_q;
        do_pop  = pop && (fq_q.lvl != '0);
        do_push = push && (fq_q.lvl != FULL_LVL);
        if (do_push) begin
            fq_d.mem[fq_q.wp] = wdata;
            fq_d.wp = (fq_q.wp == LAST_PTR) ? '0 : fq_q.wp + PTR_W'(1);
        end
        if (do_pop) begin
            fq_d.rp = (fq_q.rp == LAST_PTR) ? '0 : fq_q.rp + PTR_W'(1);
        end
        case ({do_push, do_pop})
            2'b10:   fq_d.lvl = fq_q.lvl + LVL_W'(1);
            2'b01:   fq_d.lvl = fq_q.lvl - LVL_W'(1);
            default: fq_d.lvl = fq_q.lvl;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fq_q <= '0;
        else        fq_q <= fq_d;
    end

    assign head      = fq_q.mem[fq_q.rp];
    assign not_empty = (fq_q.lvl != '0);
    assign accept    = do_push;
    assign level     = fq_q.lvl;
endmodule

// File: rtl/uart_mp_rx.sv
module uart_mp_rx
    import uart_mp_rx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int OSR         = 16,
    parameter int DEPTH       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rx_in,
    input  logic              ninth_en,
    input  logic              par_en,
    input  logic [1:0]        par_sel,
    input  logic              mp_en,
    input  logic              pop,
    input  logic              clr_perr,
    input  logic              clr_ovr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_bit9,
    output logic              rd_valid,
    output logic              perr,
    output logic              ovr,
    output logic              rx_irq
);
    localparam int ENT_W = DATA_W + 1;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic              line_s;
    logic              frm_done, frm_bit9, frm_stop;
    logic [DATA_W-1:0] frm_data;
    logic              kept_bit, exp_par, par_bad, fifo_push_ok;
    logic [ENT_W-1:0]  fifo_head;
    logic [LVL_W-1:0]  fifo_level;
    flag_s             fl_d, fl_q;

    uart_mp_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_in),
        .dout (line_s)
    );

    uart_mp_rx_frame #(.DATA_W(DATA_W), .OSR(OSR)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (os_tick),
        .line    (line_s),
        .slot9_en(ninth_en | par_en),
        .done    (frm_done),
        .data    (frm_data),
        .bit9    (frm_bit9),
        .stop_bit(frm_stop)
    );

    always_comb begin
        kept_bit = (ninth_en && !par_en) ? frm_bit9 : frm_stop;
        case (par_sel)
            PAR_ODD:  exp_par = ~(^frm_data);
            PAR_EVEN: exp_par = ^frm_data;
            PAR_MARK: exp_par = 1'b1;
            default:  exp_par = 1'b0;
        endcase
        par_bad = frm_done && par_en && (frm_bit9 != exp_par);
    end

    uart_mp_rx_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (frm_done),
        .wdata    ({kept_bit, frm_data}),
        .pop      (pop),
        .head     (fifo_head),
        .not_empty(rd_valid),
        .accept   (fifo_push_ok),
        .level    (fifo_level)
    );

    always_comb begin
        fl_d     = fl_q;
        fl_d.irq = fifo_push_ok && (!mp_en || kept_bit);
        if (par_bad)       fl_d.perr = 1'b1;
        else if (clr_perr) fl_d.perr = 1'b0;
        if (frm_done && !fifo_push_ok) fl_d.ovr = 1'b1;
        else if (clr_ovr)              fl_d.ovr = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign rd_data = fifo_head[DATA_W-1:0];
    assign rd_bit9 = fifo_head[DATA_W];
    assign perr    = fl_q.perr;
    assign ovr     = fl_q.ovr;
    assign rx_irq  = fl_q.irq;
endmodule

// File: rtl/uart_mp_rx_chk.sv
module uart_mp_rx_chk #(
    parameter int DEPTH = 2,
    parameter int LVL_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mp_en,
    input logic             clr_perr,
    input logic             clr_ovr,
    input logic             pop,
    input logic             frm_done,
    input logic             fifo_push_ok,
    input logic             kept_bit,
    input logic             rx_irq,
    input logic             perr,
    input logic             ovr,
    input logic             rd_valid,
    input logic [LVL_W-1:0] fifo_level
);
    p_level_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fifo_level) <= DEPTH);

    p_mp_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && mp_en && !kept_bit) |=> !rx_irq);

    p_irq_every_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_push_ok && !mp_en) |=> rx_irq);

    p_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq);

    p_perr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (perr && !clr_perr) |=> perr);

    p_ovr_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && !fifo_push_ok) |=> (ovr && !rx_irq));

    p_ovr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !clr_ovr) |=> ovr);

    p_empty_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_valid && pop && !frm_done) |=> !rd_valid);
endmodule

bind uart_mp_rx uart_mp_rx_chk #(.DEPTH(DEPTH), .LVL_W($clog2(DEPTH + 1))) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mp_en       (mp_en),
    .clr_perr    (clr_perr),
    .clr_ovr     (clr_ovr),
    .pop         (pop),
    .frm_done    (frm_done),
    .fifo_push_ok(fifo_push_ok),
    .kept_bit    (kept_bit),
    .rx_irq      (rx_irq),
    .perr        (perr),
    .ovr         (ovr),
    .rd_valid    (rd_valid),
    .fifo_level  (fifo_level)
);

// File: tb/tb_uart_mp_rx.sv
module tb_uart_mp_rx;
    localparam int CLK_PERIOD = 10;
    localparam int BIT_CYC    = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rx_in = 1'b1;
    logic       ninth_en = 1'b0, par_en = 1'b0, mp_en = 1'b0;
    logic [1:0] par_sel = 2'b00;
    logic       pop = 1'b0, clr_perr = 1'b0, clr_ovr = 1'b0;
    logic [7:0] rd_data;
    logic       rd_bit9, rd_valid, perr, ovr, rx_irq;

    int checks = 0;
    int fails = 0;
    int irq_seen = 0;
    int exp_irq = 0;
    logic exp_perr = 1'b0;
    logic exp_ovr = 1'b0;
    logic [8:0] exp_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_mp_rx dut (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_in(rx_in),
        .ninth_en(ninth_en), .par_en(par_en), .par_sel(par_sel), .mp_en(mp_en),
        .pop(pop), .clr_perr(clr_perr), .clr_ovr(clr_ovr),
        .rd_data(rd_data), .rd_bit9(rd_bit9), .rd_valid(rd_valid),
        .perr(perr), .ovr(ovr), .rx_irq(rx_irq)
    );

    initial forever begin
        @(negedge clk);
        os_tick = ~os_tick;
    end

    initial forever begin
        @(negedge clk);
        if (rx_irq === 1'b1) irq_seen++;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic par_of(input logic [7:0] d, input logic [1:0] sel);
        case (sel)
            2'b00:   return ~(^d);
            2'b01:   return ^d;
            2'b10:   return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic line_bit(input logic b);
        rx_in = b;
        repeat (BIT_CYC) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic b9);
        logic keep;
        logic slot;
        slot = ninth_en | par_en;
        keep = (ninth_en && !par_en) ? b9 : 1'b1;
        line_bit(1'b0);
        for (int i = 0; i < 8; i++) line_bit(d[i]);
        if (slot) line_bit(b9);
        line_bit(1'b1);
        repeat (40) @(negedge clk);
        if (par_en && (b9 !== par_of(d, par_sel))) exp_perr = 1'b1;
        if (exp_q.size() < 2) begin
            exp_q.push_back({keep, d});
            if (!mp_en || keep) exp_irq++;
        end else begin
            exp_ovr = 1'b1;
        end
    endtask

    task automatic flags(input string tag);
        chk({tag, " irq count R7 R8"}, irq_seen, exp_irq);
        chk({tag, " perr R5 R6"}, {31'd0, perr}, {31'd0, exp_perr});
        chk({tag, " ovr R10"}, {31'd0, ovr}, {31'd0, exp_ovr});
    endtask

    task automatic pop_check(input string tag);
        logic [8:0] e;
        if (exp_q.size() == 0) begin
            chk({tag, " R9 scoreboard empty"}, 1, 0);
            return;
        end
        e = exp_q.pop_front();
        chk({tag, " R9 valid"}, {31'd0, rd_valid}, 1);
        chk({tag, " R2 data"}, {24'd0, rd_data}, {24'd0, e[7:0]});
        chk({tag, " R4 status bit"}, {31'd0, rd_bit9}, {31'd0, e[8]});
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
        @(negedge clk);
    endtask

    task automatic clear_perr();
        clr_perr = 1'b1;
        @(negedge clk);
        clr_perr = 1'b0;
        @(negedge clk);
        exp_perr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(negedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        chk("R1 rd_valid", {31'd0, rd_valid}, 0);
        chk("R1 perr", {31'd0, perr}, 0);
        chk("R1 ovr", {31'd0, ovr}, 0);
        chk("R1 rx_irq", {31'd0, rx_irq}, 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);

        // R2 R4 R8: plain 8-bit frames, status bit is the stop value
        send_frame(8'hA5, 1'b0);
        flags("plain A5");
        pop_check("plain A5");
        send_frame(8'h5A, 1'b0);
        flags("plain 5A");
        pop_check("plain 5A");

        // R3 R4: extra-bit slot carries the ninth bit
        ninth_en = 1'b1;
        send_frame(8'h3C, 1'b0);
        send_frame(8'h81, 1'b1);
        flags("ninth");
        pop_check("ninth 0");
        pop_check("ninth 1");

        // R5 R6 R4: parity, which also overrides the extra-bit mode
        par_en = 1'b1;
        par_sel = 2'b01;
        send_frame(8'h03, 1'b0);
        flags("even good");
        pop_check("even good stop bit");
        send_frame(8'h03, 1'b1);
        flags("even bad");
        send_frame(8'h03, 1'b0);
        flags("R6 sticky after good frame");
        pop_check("even bad");
        pop_check("even good2");
        clear_perr();
        flags("R6 after clear");
        par_sel = 2'b00;
        send_frame(8'h07, 1'b1);
        flags("odd bad");
        pop_check("odd bad");
        clear_perr();
        send_frame(8'h07, 1'b0);
        flags("odd good");
        pop_check("odd good");
        ninth_en = 1'b0;
        par_sel = 2'b10;
        send_frame(8'h55, 1'b1);
        flags("mark good");
        send_frame(8'h55, 1'b0);
        flags("mark bad");
        pop_check("mark good");
        pop_check("mark bad");
        clear_perr();
        par_sel = 2'b11;
        send_frame(8'h55, 1'b0);
        flags("space good");
        send_frame(8'h55, 1'b1);
        flags("space bad");
        pop_check("space good");
        pop_check("space bad");
        clear_perr();

        // R7: multiprocessor mode gates the interrupt on the ninth bit
        par_en = 1'b0;
        ninth_en = 1'b1;
        mp_en = 1'b1;
        send_frame(8'h42, 1'b0);
        flags("R7 data frame");
        send_frame(8'h17, 1'b1);
        flags("R7 address frame");
        pop_check("R7 data stored");
        pop_check("R7 address stored");
        mp_en = 1'b0;
        ninth_en = 1'b0;

        // R10: third frame into a full queue is dropped
        send_frame(8'h11, 1'b0);
        send_frame(8'h22, 1'b0);
        send_frame(8'h33, 1'b0);
        flags("R10 overrun");
        pop_check("R10 first kept");
        pop_check("R10 second kept");
        chk("R10 dropped frame absent", {31'd0, rd_valid}, 0);
        clr_ovr = 1'b1;
        @(negedge clk);
        clr_ovr = 1'b0;
        @(negedge clk);
        exp_ovr = 1'b0;
        flags("R10 after clear");

        // R9: pop on empty queue is ignored
        pop = 1'b1;
        repeat (3) @(negedge clk);
        pop = 1'b0;
        @(negedge clk);
        chk("R9 pop on empty", {31'd0, rd_valid}, 0);
        send_frame(8'hC3, 1'b0);
        pop_check("R9 after empty pop");

        // R11: pop held high while a frame lands in an empty queue
        pop = 1'b1;
        fork
            send_frame(8'h6E, 1'b0);
            begin
                while (1) begin
                    @(negedge clk);
                    if (rd_valid === 1'b1) break;
                end
                pop = 1'b0;
            end
        join
        flags("R11 overlap");
        pop_check("R11 overlap entry kept");

        // R2: short low pulse is rejected as a glitch
        rx_in = 1'b0;
        repeat (8) @(negedge clk);
        rx_in = 1'b1;
        repeat (400) @(negedge clk);
        chk("R2 glitch no frame", {31'd0, rd_valid}, 0);
        flags("R2 glitch");
        send_frame(8'h99, 1'b0);
        pop_check("R2 after glitch");
        flags("final");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule